// File: doc/BRIEF.md
# Up/Down Auto-Reload Capture Timer

A 16-bit counter paired with a 16-bit companion register that holds either a reload value or a captured count. The counter advances on a prescaled system clock or on falling edges of an external count pin. On overflow it can wrap to zero, where the companion register captures the count on a trigger-pin falling edge. It can instead reload from the companion register, either on overflow or on a trigger-pin falling edge. With down-count enabled, the trigger pin sets the count direction instead.

A baud mode, chosen by either of two selects, runs the timer from the clock divided by 2 and always reloads on overflow. Each overflow in this mode gives a one-cycle tick for a serial port. A small byte-wide register bus reads and writes the counter, the companion register and the two flags.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset the counter, the companion register, both flags and the baud tick are all 0.
- R2: Bus address 0 and 1 give the counter's low and high byte, 2 and 3 the companion register's low and high byte, and 4 the flags (bit 0 overflow, bit 1 external). Reads are combinational. A write replaces the byte and takes priority over a hardware counter update in the same cycle.
- R3: In counter mode (`ctr_sel`=1) the count moves once for each falling edge of `cnt_pin`. Such an edge is a 1 sampled on one clock followed by a 0 on the next. In timer mode the count moves once every 12 clocks while `run` is high, counting from the clock on which `run` rises. With `run` low the count holds.
- R4: With `cap_sel`=0 and `dn_en`=0, a count step from 0xFFFF loads the companion register value and sets the overflow flag.
- R5: With `cap_sel`=1 outside baud mode, a step from 0xFFFF wraps to 0 and sets the overflow flag. With `ext_en`=1 as well, a `trg_pin` falling edge copies the counter into the companion register, sets the external flag and leaves the count unchanged.
- R6: With `cap_sel`=0, `dn_en`=0 and `ext_en`=1, a `trg_pin` falling edge loads the counter from the companion register and sets the external flag. With `ext_en`=0, trigger edges change neither the counter nor the flags.
- R7: With `dn_en`=1 outside baud mode, `trg_pin` high counts up and 0xFFFF steps to the companion value. `trg_pin` low counts down, and a step from the companion value loads 0xFFFF. Each such wrap sets the overflow flag and toggles the external flag. Trigger edges cause no reload or capture.
- R8: When `rx_baud` or `tx_baud` is 1, the timer-mode prescale is 2. `cap_sel` and `dn_en` are ignored, so a step from 0xFFFF always loads the companion value. The wrap pulses `baud_tick` high for one cycle and does not set the overflow flag.
- R9: Flags stay set until a bus write of 0 to their bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cnt_pin | input | 1 | External count pin |
| trg_pin | input | 1 | Trigger / direction pin |
| run | input | 1 | Counting enable |
| ctr_sel | input | 1 | 1: count pin edges, 0: prescaled clock |
| cap_sel | input | 1 | 1: capture, 0: auto-reload |
| ext_en | input | 1 | Enables trigger-pin capture/reload |
| dn_en | input | 1 | Enables pin-controlled up/down counting |
| rx_baud | input | 1 | Baud select, receive |
| tx_baud | input | 1 | Baud select, transmit |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 3 | Bus register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External flag |
| baud_tick | output | 1 | One-cycle pulse on baud-mode overflow |

## Verification
The hardest case to reach is a down-count wrap. The counter has to sit exactly on the companion value while the direction pin is low, and the external flag's state then depends on how many wraps have happened so far. The stimulus loads the counter and the companion register through the bus to within a few steps of the boundary. It then sends a random number of count-pin pulses. Expected count and flag parity come from a reference step function. The up-count wrap from 0xFFFF uses the same near-boundary preload.

// File: rtl/updn_reload_timer.sv
module updn_reload_timer #(
  parameter int W    = 16,
  parameter int TDIV = 12,
  parameter int BDIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_pin,
  input  logic       trg_pin,
  input  logic       run,
  input  logic       ctr_sel,
  input  logic       cap_sel,
  input  logic       ext_en,
  input  logic       dn_en,
  input  logic       rx_baud,
  input  logic       tx_baud,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       ovf_flag,
  output logic       ext_flag,
  output logic       baud_tick
);
  localparam int PW = $clog2(TDIV > BDIV ? TDIV : BDIV);
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0]  cnt, rld, cnt_hw;
  logic [PW-1:0] pre;
  logic c1, c2, t1, t2;

  wire baud     = rx_baud | tx_baud;
  wire cnt_fall = c2 & ~c1;
  wire trg_fall = t2 & ~t1;
  wire [PW-1:0] lim = baud ? PW'(BDIV - 1) : PW'(TDIV - 1);
  wire tick     = run & (ctr_sel ? cnt_fall : (pre >= lim));
  wire updn     = dn_en & ~baud;
  wire down     = updn & ~t1;
  wire wrap     = tick & (down ? (cnt == rld) : (cnt == ONES));
  wire reld     = ~cap_sel | baud | updn;
  wire edge_act = ext_en & ~updn & trg_fall;
  wire do_cap   = edge_act & cap_sel & ~baud;
  wire do_trl   = edge_act & ~cap_sel & ~baud;
  wire wr_flags = bus_wr & (bus_addr == 3'd4);
  wire ovf_base = wr_flags ? bus_wdata[0] : ovf_flag;
  wire ext_base = wr_flags ? bus_wdata[1] : ext_flag;

  always_comb begin
    cnt_hw = cnt;
    if (tick) begin
      if (wrap)      cnt_hw = down ? ONES : (reld ? rld : '0);
      else if (down) cnt_hw = cnt - 1'b1;
      else           cnt_hw = cnt + 1'b1;
    end
    if (do_trl) cnt_hw = rld;
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = cnt[7:0];
      3'd1:    bus_rdata = 8'(cnt >> 8);
      3'd2:    bus_rdata = rld[7:0];
      3'd3:    bus_rdata = 8'(rld >> 8);
      3'd4:    bus_rdata = {6'd0, ext_flag, ovf_flag};
      default: bus_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; rld <= '0; pre <= '0;
      c1 <= 1'b0; c2 <= 1'b0; t1 <= 1'b0; t2 <= 1'b0;
      ovf_flag <= 1'b0; ext_flag <= 1'b0; baud_tick <= 1'b0;
    end else begin
      c1 <= cnt_pin; c2 <= c1;
      t1 <= trg_pin; t2 <= t1;
      pre <= (!run || pre >= lim) ? '0 : pre + 1'b1;

      cnt <= cnt_hw;
      if (bus_wr && bus_addr == 3'd0) cnt[7:0]   <= bus_wdata;
      if (bus_wr && bus_addr == 3'd1) cnt[W-1:8] <= bus_wdata[W-9:0];

      if (do_cap) rld <= cnt;
      if (bus_wr && bus_addr == 3'd2) rld[7:0]   <= bus_wdata;
      if (bus_wr && bus_addr == 3'd3) rld[W-1:8] <= bus_wdata[W-9:0];

      ovf_flag  <= ovf_base | (wrap & ~baud);
      ext_flag  <= (updn & wrap) ? ~ext_base : (ext_base | edge_act);
      baud_tick <= wrap & baud;
    end
  end
endmodule

module updn_reload_timer_chk #(parameter int W = 16) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         ext_en,
  input logic         dn_en,
  input logic         rx_baud,
  input logic         tx_baud,
  input logic         bus_wr,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] rld,
  input logic         ovf_flag,
  input logic         ext_flag,
  input logic         baud_tick
);
  // R8
  baud_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(rx_baud | tx_baud));
  // R8
  baud_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);
  // R4
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) && !$past(bus_wr)) |-> ($past(cnt) == {W{1'b1}} || $past(cnt == rld)));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr && !ext_en) |=> $stable(cnt));
  // R9
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(bus_wr && bus_addr == 3'd4));
  // R9
  ext_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_flag) |-> $past((bus_wr && bus_addr == 3'd4) || dn_en));
endmodule

bind updn_reload_timer updn_reload_timer_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .ext_en(ext_en), .dn_en(dn_en),
  .rx_baud(rx_baud), .tx_baud(tx_baud), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cnt(cnt), .rld(rld), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
  .baud_tick(baud_tick));

// File: tb/updn_reload_timer_tb_top.sv
`timescale 1ns/1ps
module updn_reload_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic cnt_pin = 0, trg_pin = 1, run = 0, ctr_sel = 1, cap_sel = 0, ext_en = 0, dn_en = 0;
  logic rx_baud = 0, tx_baud = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic ovf_flag, ext_flag, baud_tick;
  int ncheck = 0, nfail = 0;

  always #2.5 clk = ~clk;

  updn_reload_timer dut_i (.*);

  task automatic chk(input string tag, input int got, input int exp);
    ncheck++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] v);
    wr(a, v[7:0]); wr(a + 3'd1, v[15:8]);
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); bus_addr = a; #1 v[7:0] = bus_rdata;
    bus_addr = a + 3'd1; #1 v[15:8] = bus_rdata;
  endtask

  task automatic pulse_cnt();
    @(negedge clk); cnt_pin = 1; repeat (2) @(negedge clk);
    cnt_pin = 0; repeat (3) @(negedge clk);
  endtask

  task automatic fall_trg();
    @(negedge clk); trg_pin = 1; repeat (2) @(negedge clk);
    trg_pin = 0; repeat (3) @(negedge clk);
    trg_pin = 1; repeat (3) @(negedge clk);
  endtask

  // reference step: returns {wraps, count}
  function automatic logic [31:0] model(input logic [15:0] c, input logic [15:0] r,
                                        input int n, input bit dn, input bit rel);
    int w = 0;
    for (int i = 0; i < n; i++) begin
      if (dn) begin
        if (c == r) begin c = 16'hFFFF; w++; end else c = c - 1;
      end else begin
        if (c == 16'hFFFF) begin c = rel ? r : 16'h0; w++; end else c = c + 1;
      end
    end
    return {w[15:0], c};
  endfunction

  initial begin
    repeat (1000000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end

  initial begin
    logic [15:0] v, r, s;
    logic [31:0] m;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R1
    rd16(0, v); chk("R1 count", v, 0);
    rd16(2, v); chk("R1 reload", v, 0);
    chk("R1 ovf", ovf_flag, 0); chk("R1 ext", ext_flag, 0); chk("R1 tick", baud_tick, 0);
    rst_n = 1;
    // R2
    wr16(0, 16'hA55A); rd16(0, v); chk("R2 count rw", v, 16'hA55A);
    wr16(2, 16'h1234); rd16(2, v); chk("R2 reload rw", v, 16'h1234);
    wr(4, 8'h03); chk("R2 flags rw", {ext_flag, ovf_flag}, 3);
    wr(4, 8'h00); chk("R9 flags cleared", {ext_flag, ovf_flag}, 0);
    // R3 timer mode 12
    wr16(0, 0); ctr_sel = 0;
    @(negedge clk); run = 1; repeat (120) @(posedge clk); @(negedge clk); run = 0;
    rd16(0, v); chk("R3 timer /12", v, 10);
    repeat (30) @(negedge clk); rd16(0, v); chk("R3 hold run low", v, 10);
    // R8 baud /2 with reload, cap_sel ignored
    wr16(0, 0); tx_baud = 1; cap_sel = 1;
    @(negedge clk); run = 1; repeat (20) @(posedge clk); @(negedge clk); run = 0;
    rd16(0, v); chk("R8 baud /2", v, 10);
    wr16(0, 16'hFFFE); wr16(2, 16'h4321);
    @(negedge clk); run = 1; repeat (4) @(posedge clk); @(negedge clk); run = 0;
    chk("R8 baud tick", baud_tick, 1);
    rd16(0, v); chk("R8 baud reload", v, 16'h4321);
    chk("R8 no ovf", ovf_flag, 0);
    tx_baud = 0; cap_sel = 0; ctr_sel = 1; run = 1;
    // R3/R4 random up auto-reload
    for (int i = 0; i < 16; i++) begin
      int n;
      r = 16'($urandom % 16'hF000); s = 16'hFFFF - 16'($urandom % 4); n = 1 + $urandom % 6;
      wr16(2, r); wr16(0, s); wr(4, 0);
      for (int j = 0; j < n; j++) pulse_cnt();
      m = model(s, r, n, 0, 1);
      rd16(0, v); chk("R4 up reload count", v, m[15:0]);
      chk("R4 ovf", ovf_flag, m[31:16] != 0);
    end
    // R9 flag persists
    wr16(0, 16'hFFFF); wr(4, 0); pulse_cnt(); pulse_cnt(); pulse_cnt();
    chk("R9 ovf persists", ovf_flag, 1);
    // R5 capture mode
    cap_sel = 1; wr(4, 0); wr16(0, 16'hFFFF); pulse_cnt();
    rd16(0, v); chk("R5 wrap to zero", v, 0); chk("R5 ovf", ovf_flag, 1);
    ext_en = 1; wr16(0, 16'h0BCD); fall_trg();
    rd16(2, v); chk("R5 captured", v, 16'h0BCD);
    rd16(0, v); chk("R5 count kept", v, 16'h0BCD); chk("R5 ext", ext_flag, 1);
    // R6 trigger reload
    cap_sel = 0; wr(4, 0); wr16(2, 16'h5A5A); wr16(0, 16'h0011); fall_trg();
    rd16(0, v); chk("R6 trigger reload", v, 16'h5A5A); chk("R6 ext", ext_flag, 1);
    ext_en = 0; wr(4, 0); wr16(0, 16'h0022); fall_trg();
    rd16(0, v); chk("R6 ignored count", v, 16'h0022); chk("R6 ignored ext", ext_flag, 0);
    // R7 down counting, random
    dn_en = 1; ext_en = 1; trg_pin = 0; repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      int n;
      r = 16'($urandom % 16'hF000); s = r + 16'($urandom % 4); n = 1 + $urandom % 6;
      wr16(2, r); wr16(0, s); wr(4, 0);
      for (int j = 0; j < n; j++) pulse_cnt();
      m = model(s, r, n, 1, 1);
      rd16(0, v); chk("R7 down count", v, m[15:0]);
      chk("R7 down ovf", ovf_flag, m[31:16] != 0);
      chk("R7 ext toggle", ext_flag, m[16]);
    end
    // R7 up with direction high, two wraps
    trg_pin = 1; repeat (3) @(negedge clk);
    wr16(2, 16'hFFFE); wr16(0, 16'hFFFE); wr(4, 0);
    repeat (4) pulse_cnt();
    m = model(16'hFFFE, 16'hFFFE, 4, 0, 1);
    rd16(0, v); chk("R7 up count", v, m[15:0]);
    chk("R7 up ext parity", ext_flag, m[16]); chk("R7 up ovf", ovf_flag, 1);
    wr(4, 0); wr16(0, 16'h0100); fall_trg();
    rd16(0, v); chk("R7 no trigger reload", v, 16'h0100);
    chk("R7 no trigger ext", ext_flag, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", ncheck, nfail);
    $finish;
  end
endmodule